// File: doc/BRIEF.md
# Additive Oscillator Bank State Engine

This block keeps the running state of a bank of additive-synthesis oscillators and moves every oscillator forward by one sample per sample period. Each oscillator slot owns four 16-bit words: a slope, a frequency, a phase and an amplitude. A sweep counter visits one slot per clock. A sweep that executes adds the frequency to the phase, with wraparound. It also adds the signed slope to the amplitude, which saturates at both ends. A flag in the slope word lets a slot ramp its amplitude only on one sample out of every `SLOW_DIV`.

A processor port reaches every slot word, a control word and a status word. The port is granted only in recurring access cycles, so the wait for a grant varies. Downstream waveform and mixing logic receives a registered stream of the slot number, phase, amplitude and noise-select flag. Amplitude is forced to zero for silent slots and while mute is active.

Top module: `pe_engine`

## Requirements
- R1: After reset the engine is halted and muted, every slot word is zero, `out_valid` and `out_amp` are 0, and the status word reads 0x0009.
- R2: The word address is {region, slot, sel}. When region (the top bit) is 0, sel 0 selects slope, 1 frequency, 2 phase and 3 amplitude of the chosen slot. When region is 1, a write goes to the control word and a read returns the status word.
- R3: `cpu_ready` equals `cpu_req` in cycles where the sweep index is a multiple of `ACCESS_STRIDE` and is 0 otherwise. A write takes effect and a read returns data only in a ready cycle.
- R4: Each executed sweep adds frequency bits 14:0 to the slot phase modulo 65536. Frequency bit 15 is not added and appears as `out_noise`.
- R5: Amplitude is unsigned. When adding the slope value would go below 0 the result is 0, and when it would go above 0xFFFF the result is 0xFFFF.
- R6: The slope value is bit 15 sign-extended over bits 13:0. When bit 14 is 0 the slope is applied every executed sample. When bit 14 is 1 it is applied only on a slow-tick sample. The slow tick is the first executed sample after reset and then every `SLOW_DIV`-th executed sample.
- R7: Control bit 0 is run (1) or halt (0). Sweeps start and stop only at slot 0. While halted, no slot state changes except through processor writes.
- R8: Writing control bit 1 as 1 executes exactly one full sweep, starting at the next slot-0 boundary.
- R9: `out_amp` is 0 when control bit 3 is 0 (mute) or when the slot index is a multiple of `SILENT_STRIDE`. Other control bits are ignored.
- R10: Status bit 0 is the access cycle, bit 1 is the run bit, bit 3 is set when the current sample is a slow-tick sample, and all other bits are 0.
- R11: When a processor write hits the register that the engine is updating in the same cycle, the written value wins.
- R12: One cycle after slot k is swept, `out_slot` is k, `out_phase` is the phase before the update, and `out_valid` is 1 if that sweep executed. `out_slot` advances every clock even while halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW (SLOT_BITS+3) | Word address {region, slot, sel} |
| cpu_wdata | input | 16 | Write data |
| cpu_ready | output | 1 | Access granted this cycle |
| cpu_rdata | output | 16 | Read data, valid while ready |
| out_valid | output | 1 | Output belongs to an executed sweep |
| out_slot | output | SLOT_BITS | Slot number of the output |
| out_phase | output | 16 | Slot phase before this sweep's update |
| out_amp | output | 16 | Slot amplitude, zero when silent or muted |
| out_noise | output | 1 | Frequency bit 15 of the slot |

## Verification
The bench builds the engine with 32 slots, a silent and access stride of 16, and a slow divider of 4. With these values a full sweep lasts only 32 clocks, and both access cycles (slots 0 and 16) fall inside every sweep. Single steps let the bench count executed samples exactly, so five steps cover a full slow-tick period and the following fast samples. Slot 16 is both silent and an access slot, so the silent blanking and the processor-wins override can both be placed on cycles the bench predicts.

// File: rtl/pe_pkg.sv
package pe_pkg;
   localparam int WORD_W = 16;

   typedef enum logic [1:0] {
      SEL_SLOPE = 2'd0,
      SEL_FREQ  = 2'd1,
      SEL_PHASE = 2'd2,
      SEL_AMP   = 2'd3
   } reg_sel_e;

   localparam int CTL_RUN    = 0;
   localparam int CTL_STEP   = 1;
   localparam int CTL_NORMAL = 3;

   localparam int ST_ACCESS = 0;
   localparam int ST_RUN    = 1;
   localparam int ST_SLOW   = 3;

   // numeric slope: sign bit spread over the rate flag position
   function automatic logic signed [17:0] slope_value(input logic [WORD_W-1:0] s);
      return {{4{s[15]}}, s[13:0]};
   endfunction
endpackage

// File: rtl/pe_timebase.sv
module pe_timebase #(
   parameter int SLOTS         = 256,
   parameter int ACCESS_STRIDE = 16,
   parameter int SLOW_DIV      = 16,
   localparam int SB = $clog2(SLOTS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_i,
   input  logic          step_wr_i,
   output logic [SB-1:0] idx_o,
   output logic          exec_o,
   output logic          access_o,
   output logic          slow_tick_o
);
   localparam logic [SB-1:0] LAST = SB'(SLOTS - 1);

   logic step_pend;
   logic boundary;

   assign boundary = (idx_o == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_o     <= '0;
         exec_o    <= 1'b0;
         step_pend <= 1'b0;
      end else begin
         idx_o     <= boundary ? '0 : idx_o + 1'b1;
         step_pend <= (step_pend & ~boundary) | step_wr_i;
         if (boundary) exec_o <= run_i | step_pend;
      end
   end

   generate
      if (ACCESS_STRIDE == 1) begin : g_acc_all
         assign access_o = 1'b1;
      end else begin : g_acc_stride
         localparam int AB = $clog2(ACCESS_STRIDE);
         assign access_o = (idx_o[AB-1:0] == '0);
      end

      if (SLOW_DIV == 1) begin : g_slow_all
         assign slow_tick_o = 1'b1;
      end else begin : g_slow_cnt
         localparam int CB = $clog2(SLOW_DIV);
         localparam logic [CB-1:0] CNT_LAST = CB'(SLOW_DIV - 1);
         logic [CB-1:0] samp_cnt;
         always_ff @(posedge clk) begin
            if (!rst_n) samp_cnt <= '0;
            else if (boundary && exec_o)
               samp_cnt <= (samp_cnt == CNT_LAST) ? '0 : samp_cnt + 1'b1;
         end
         assign slow_tick_o = (samp_cnt == '0);

         assert_samp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !exec_o |=> $stable(samp_cnt));
      end
   endgenerate

   assert_idx_wrap_R12: assert property (@(posedge clk) disable iff (!rst_n)
      boundary |=> (idx_o == '0));
endmodule

// File: rtl/pe_step_math.sv
module pe_step_math
   import pe_pkg::*;
(
   input  logic [WORD_W-1:0] slope_i,
   input  logic [WORD_W-1:0] freq_i,
   input  logic [WORD_W-1:0] phase_i,
   input  logic [WORD_W-1:0] amp_i,
   input  logic              slow_tick_i,
   output logic [WORD_W-1:0] phase_o,
   output logic [WORD_W-1:0] amp_o
);
   logic signed [17:0] sum;
   logic               apply;

   always_comb begin
      phase_o = phase_i + {1'b0, freq_i[14:0]};
      apply   = !slope_i[14] || slow_tick_i;
      sum     = $signed({2'b00, amp_i}) + slope_value(slope_i);
      if (!apply)                  amp_o = amp_i;
      else if (sum < 0)            amp_o = '0;
      else if (sum > 18'sd65535)   amp_o = '1;
      else                         amp_o = sum[15:0];
   end

   always_comb begin
      if (!slope_i[15]) assert_amp_no_wrap_up_R5: assert (amp_o >= amp_i);
      else              assert_amp_no_wrap_down_R5: assert (amp_o <= amp_i);
      if (slope_i[14] && !slow_tick_i) assert_slow_hold_R6: assert (amp_o == amp_i);
   end
endmodule

// File: rtl/pe_bank.sv
module pe_bank
   import pe_pkg::*;
#(
   parameter int SLOTS = 256,
   localparam int SB = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              eng_we,
   input  logic [SB-1:0]     eng_idx,
   input  logic [WORD_W-1:0] eng_phase,
   input  logic [WORD_W-1:0] eng_amp,
   output logic [WORD_W-1:0] cur_slope,
   output logic [WORD_W-1:0] cur_freq,
   output logic [WORD_W-1:0] cur_phase,
   output logic [WORD_W-1:0] cur_amp,
   input  logic              cpu_wr,
   input  logic [SB-1:0]     cpu_slot,
   input  reg_sel_e          cpu_sel,
   input  logic [WORD_W-1:0] cpu_wdata,
   output logic [WORD_W-1:0] cpu_rd
);
   logic [WORD_W-1:0] slope_r [SLOTS];
   logic [WORD_W-1:0] freq_r  [SLOTS];
   logic [WORD_W-1:0] phase_r [SLOTS];
   logic [WORD_W-1:0] amp_r   [SLOTS];

   logic cpu_hits_phase, cpu_hits_amp;
   assign cpu_hits_phase = cpu_wr && cpu_sel == SEL_PHASE && cpu_slot == eng_idx;
   assign cpu_hits_amp   = cpu_wr && cpu_sel == SEL_AMP   && cpu_slot == eng_idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < SLOTS; i++) begin
            slope_r[i] <= '0;
            freq_r[i]  <= '0;
            phase_r[i] <= '0;
            amp_r[i]   <= '0;
         end
      end else begin
         if (eng_we && !cpu_hits_phase) phase_r[eng_idx] <= eng_phase;
         if (eng_we && !cpu_hits_amp)   amp_r[eng_idx]   <= eng_amp;
         if (cpu_wr) begin
            unique case (cpu_sel)
               SEL_SLOPE: slope_r[cpu_slot] <= cpu_wdata;
               SEL_FREQ:  freq_r[cpu_slot]  <= cpu_wdata;
               SEL_PHASE: phase_r[cpu_slot] <= cpu_wdata;
               SEL_AMP:   amp_r[cpu_slot]   <= cpu_wdata;
            endcase
         end
      end
   end

   assign cur_slope = slope_r[eng_idx];
   assign cur_freq  = freq_r[eng_idx];
   assign cur_phase = phase_r[eng_idx];
   assign cur_amp   = amp_r[eng_idx];

   always_comb begin
      unique case (cpu_sel)
         SEL_SLOPE: cpu_rd = slope_r[cpu_slot];
         SEL_FREQ:  cpu_rd = freq_r[cpu_slot];
         SEL_PHASE: cpu_rd = phase_r[cpu_slot];
         SEL_AMP:   cpu_rd = amp_r[cpu_slot];
      endcase
   end

   assert_cpu_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_sel == SEL_PHASE) |=> phase_r[$past(cpu_slot)] == $past(cpu_wdata));
endmodule

// File: rtl/pe_engine.sv
module pe_engine
   import pe_pkg::*;
#(
   parameter int SLOTS         = 256,
   parameter int SILENT_STRIDE = 16,
   parameter int ACCESS_STRIDE = 16,
   parameter int SLOW_DIV      = 16,
   localparam int SB = $clog2(SLOTS),
   localparam int AW = SB + 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [AW-1:0]     cpu_addr,
   input  logic [WORD_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic [WORD_W-1:0] cpu_rdata,
   output logic              out_valid,
   output logic [SB-1:0]     out_slot,
   output logic [WORD_W-1:0] out_phase,
   output logic [WORD_W-1:0] out_amp,
   output logic              out_noise
);
   generate
      if (SLOTS < 2 || (SLOTS & (SLOTS - 1)) != 0) begin : g_bad_slots
         $error("SLOTS must be a power of two of at least 2");
      end
      if (SILENT_STRIDE < 2 || (SILENT_STRIDE & (SILENT_STRIDE - 1)) != 0 || SILENT_STRIDE > SLOTS) begin : g_bad_silent
         $error("SILENT_STRIDE must be a power of two between 2 and SLOTS");
      end
      if (ACCESS_STRIDE < 1 || (ACCESS_STRIDE & (ACCESS_STRIDE - 1)) != 0 || ACCESS_STRIDE > SLOTS) begin : g_bad_access
         $error("ACCESS_STRIDE must be a power of two no larger than SLOTS");
      end
      if (SLOW_DIV < 1 || (SLOW_DIV & (SLOW_DIV - 1)) != 0) begin : g_bad_slow
         $error("SLOW_DIV must be a power of two");
      end
   endgenerate

   logic [SB-1:0]     idx;
   logic              exec, access, slow_tick;
   logic              ctrl_run, ctrl_norm;
   logic              granted, ctl_wr, reg_wr, is_ctl, silent;
   logic [SB-1:0]     a_slot;
   reg_sel_e          a_sel;
   logic [WORD_W-1:0] c_slope, c_freq, c_phase, c_amp, n_phase, n_amp, bank_rd, status;

   assign is_ctl    = cpu_addr[AW-1];
   assign a_slot    = cpu_addr[AW-2:2];
   assign a_sel     = reg_sel_e'(cpu_addr[1:0]);
   assign granted   = cpu_req && access;
   assign cpu_ready = granted;
   assign ctl_wr    = granted && cpu_we && is_ctl;
   assign reg_wr    = granted && cpu_we && !is_ctl;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_run  <= 1'b0;
         ctrl_norm <= 1'b0;
      end else if (ctl_wr) begin
         ctrl_run  <= cpu_wdata[CTL_RUN];
         ctrl_norm <= cpu_wdata[CTL_NORMAL];
      end
   end

   pe_timebase #(.SLOTS(SLOTS), .ACCESS_STRIDE(ACCESS_STRIDE), .SLOW_DIV(SLOW_DIV)) u_tb (
      .clk(clk), .rst_n(rst_n), .run_i(ctrl_run), .step_wr_i(ctl_wr && cpu_wdata[CTL_STEP]),
      .idx_o(idx), .exec_o(exec), .access_o(access), .slow_tick_o(slow_tick));

   pe_bank #(.SLOTS(SLOTS)) u_bank (
      .clk(clk), .rst_n(rst_n), .eng_we(exec), .eng_idx(idx),
      .eng_phase(n_phase), .eng_amp(n_amp),
      .cur_slope(c_slope), .cur_freq(c_freq), .cur_phase(c_phase), .cur_amp(c_amp),
      .cpu_wr(reg_wr), .cpu_slot(a_slot), .cpu_sel(a_sel), .cpu_wdata(cpu_wdata),
      .cpu_rd(bank_rd));

   pe_step_math u_math (
      .slope_i(c_slope), .freq_i(c_freq), .phase_i(c_phase), .amp_i(c_amp),
      .slow_tick_i(slow_tick), .phase_o(n_phase), .amp_o(n_amp));

   localparam int SSB = $clog2(SILENT_STRIDE);
   assign silent = (idx[SSB-1:0] == '0);

   always_comb begin
      status            = '0;
      status[ST_ACCESS] = access;
      status[ST_RUN]    = ctrl_run;
      status[ST_SLOW]   = slow_tick;
   end
   assign cpu_rdata = is_ctl ? status : bank_rd;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_slot  <= '0;
         out_phase <= '0;
         out_amp   <= '0;
         out_noise <= 1'b0;
      end else begin
         out_valid <= exec;
         out_slot  <= idx;
         out_phase <= c_phase;
         out_amp   <= (silent || !ctrl_norm) ? '0 : c_amp;
         out_noise <= c_freq[15];
      end
   end

   assert_mute_blanks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_norm |=> out_amp == '0);
   assert_ready_in_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |=> out_slot[$clog2(ACCESS_STRIDE > 1 ? ACCESS_STRIDE : 2)-1:0] == '0 || ACCESS_STRIDE == 1);
endmodule

// File: tb/pe_engine_test.sv
`timescale 1ns/1ps
module pe_engine_test;
   localparam int SLOTS = 32;
   localparam int SB    = $clog2(SLOTS);
   localparam int AW    = SB + 3;
   localparam logic [AW-1:0] CTL = AW'(1) << (AW - 1);

   logic clk = 1'b0, rst_n = 1'b0;
   logic cpu_req = 0, cpu_we = 0;
   logic [AW-1:0] cpu_addr = '0;
   logic [15:0] cpu_wdata = '0;
   logic cpu_ready, out_valid, out_noise;
   logic [15:0] cpu_rdata, out_phase, out_amp;
   logic [SB-1:0] out_slot;

   int n_chk = 0, n_bad = 0, valid_cnt = 0;
   logic [15:0] cap5_phase, cap5_amp, cap7_amp, cap16_amp;
   logic cap5_noise;

   always #2.5 clk = ~clk;

   pe_engine #(.SLOTS(SLOTS), .SILENT_STRIDE(16), .ACCESS_STRIDE(16), .SLOW_DIV(4)) uut (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
      .out_valid(out_valid), .out_slot(out_slot), .out_phase(out_phase),
      .out_amp(out_amp), .out_noise(out_noise));

   always @(negedge clk) if (rst_n && out_valid) begin
      valid_cnt++;
      if (out_slot == 5) begin cap5_phase = out_phase; cap5_amp = out_amp; cap5_noise = out_noise; end
      if (out_slot == 7)  cap7_amp  = out_amp;
      if (out_slot == 16) cap16_amp = out_amp;
   end

   function automatic logic [AW-1:0] ra(int slot, int sel);
      return AW'((slot << 2) | sel);
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic acc(input logic we, input logic [AW-1:0] a, input logic [15:0] d, output logic [15:0] rd);
      @(negedge clk);
      cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
      #1;
      while (!cpu_ready) begin @(negedge clk); #1; end
      rd = cpu_rdata;
      @(posedge clk); #1;
      cpu_req = 0; cpu_we = 0;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
      logic [15:0] x;
      acc(1'b1, a, d, x);
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [15:0] v);
      acc(1'b0, a, 16'h0, v);
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic step(input logic [15:0] ctl);
      wr(CTL, ctl | 16'h0002);
      idle(3 * SLOTS);
   endtask

   task automatic t_reset;
      logic [15:0] v;
      @(negedge clk);
      chk("R1 out_valid", out_valid, 0);
      chk("R1 out_amp", out_amp, 0);
      rd(CTL, v);
      chk("R1/R10 status", v, 16'h0009);
      rd(ra(9, 3), v);
      chk("R1 amp zero", v, 0);
   endtask

   task automatic t_access_window;
      int bad = 0;
      @(negedge clk);
      cpu_req = 1; cpu_we = 0; cpu_addr = CTL;
      for (int i = 0; i < SLOTS; i++) begin
         #1;
         if (cpu_ready !== (((out_slot + 1) % 16) == 0)) bad++;
         @(negedge clk);
      end
      cpu_req = 0;
      chk("R3 ready only in access cycles", bad, 0);
   endtask

   task automatic t_regs;
      logic [15:0] v;
      wr(ra(5, 0), 16'h0010); wr(ra(5, 1), 16'h8123);
      wr(ra(5, 2), 16'hFFF0); wr(ra(5, 3), 16'hFFF8);
      wr(ra(6, 0), 16'hBFFB); wr(ra(6, 3), 16'h0003);
      wr(ra(7, 0), 16'h4002); wr(ra(7, 3), 16'd100);
      wr(ra(16, 3), 16'h1234);
      rd(ra(5, 0), v); chk("R2 slope", v, 16'h0010);
      rd(ra(5, 1), v); chk("R2 freq", v, 16'h8123);
      rd(ra(5, 2), v); chk("R2 phase", v, 16'hFFF0);
      rd(ra(5, 3), v); chk("R2 amp", v, 16'hFFF8);
      idle(100);
      rd(ra(5, 2), v); chk("R7 halted phase frozen", v, 16'hFFF0);
      chk("R7 no valid output when halted", valid_cnt, 0);
   endtask

   task automatic t_steps;
      logic [15:0] v;
      step(16'h0000);
      chk("R8 one sweep per step", valid_cnt, SLOTS);
      chk("R12 out_phase pre-update", cap5_phase, 16'hFFF0);
      chk("R4 noise flag out", cap5_noise, 1);
      chk("R9 muted amp", cap5_amp, 0);
      rd(ra(5, 2), v); chk("R4 phase wrap", v, 16'h0113);
      rd(ra(5, 3), v); chk("R5 saturate high", v, 16'hFFFF);
      rd(ra(6, 3), v); chk("R5 saturate low", v, 16'h0000);
      rd(ra(7, 3), v); chk("R6 slow applied on tick", v, 16'd102);
      rd(CTL, v);      chk("R10 status after one sample", v, 16'h0001);
      step(16'h0000); step(16'h0000); step(16'h0000);
      rd(ra(7, 3), v); chk("R6 slow held off tick", v, 16'd102);
      step(16'h0000);
      rd(ra(7, 3), v); chk("R6 slow applied next tick", v, 16'd104);
      rd(ra(5, 2), v); chk("R4 five samples", v, 16'h059F);
      chk("R8 five sweeps", valid_cnt, 5 * SLOTS);
   endtask

   task automatic t_mute;
      step(16'h0008);
      chk("R9 unmuted amp", cap7_amp, 16'd104);
      chk("R9 unmuted sat amp", cap5_amp, 16'hFFFF);
      chk("R9 silent slot blank", cap16_amp, 0);
   endtask

   task automatic t_run;
      logic [15:0] v, a, b;
      wr(CTL, 16'h0009);
      rd(CTL, v); chk("R10 run bit", v & 16'h0003, 16'h0003);
      idle(200);
      wr(CTL, 16'h0008);
      idle(100);
      chk("R7 whole sweeps only", valid_cnt % SLOTS, 0);
      chk("R7 run executed more", valid_cnt > 6 * SLOTS, 1);
      rd(ra(5, 2), a); idle(100); rd(ra(5, 2), b);
      chk("R7 halt freezes", b, a);
   endtask

   task automatic t_override;
      logic [15:0] v;
      wr(ra(0, 1), 16'h0100); wr(ra(0, 2), 16'h0000);
      wr(CTL, 16'h0009);
      idle(80);
      do @(negedge clk); while (out_slot != SB'(SLOTS - 1));
      cpu_req = 1; cpu_we = 1; cpu_addr = ra(0, 2); cpu_wdata = 16'h5000;
      #1;
      chk("R3 ready at slot 0", cpu_ready, 1);
      @(posedge clk); #1;
      cpu_req = 0; cpu_we = 0;
      rd(ra(0, 2), v);
      chk("R11 cpu write wins", v, 16'h5000);
      wr(CTL, 16'h0008);
   endtask

   initial begin
      #(5.0 * 150000);
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1;
      t_reset;
      t_access_window;
      t_regs;
      t_steps;
      t_mute;
      t_run;
      t_override;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule